// File: doc/BRIEF.md
# Edge-Triggered Word Stack with Selectable Retrieval Order

This block buffers 16-bit words in a small array of slots. A load request stores the input word and an unload request takes a word out. Each command acts once per rising edge of its own request line, so a request held high for many cycles counts as one command. A build-time parameter selects the retrieval order. In queue order the oldest word leaves first and all remaining words move down one slot. In stack order the most recently loaded word leaves first.

A position count reports how many words are held, and full and empty flags are derived from it. Loading into a full buffer or unloading an empty one leaves the contents alone and sets an error flag. The flag stays set until a synchronous clear input is asserted. When load and unload edges arrive in the same cycle, the unload is applied first and the load second. This lets a full buffer accept a new word in the same cycle that it gives one up.

Every result appears at the outputs one clock after the edge at which the block first samples the request high.

Top module: `word_stack`

## Requirements
- R1: While rst_ni is low and after its release, count_o is 0, empty_o is 1, full_o is 0, err_o is 0 and data_o is 0.
- R2: A load happens only on a rising edge of load_req_i, which is a clock at which load_req_i is 1 after being 0 at the previous clock. Holding load_req_i high causes no further loads. A successful load stores data_i in slot count_o and raises count_o by 1.
- R3: An unload happens only on a rising edge of unload_req_i. Holding unload_req_i high causes no further unloads. A successful unload lowers count_o by 1.
- R4: With ORDER = ORDER_FIFO (encoding 0), an unload drives data_o with slot 0, which holds the oldest word. Every other held word then moves down one slot.
- R5: With ORDER = ORDER_LIFO (encoding 1), an unload drives data_o with slot count_o-1, which holds the most recently loaded word.
- R6: count_o equals the number of words held and never exceeds DEPTH. empty_o is 1 exactly when count_o is 0, and full_o is 1 exactly when count_o equals DEPTH.
- R7: A load edge while full sets err_o and leaves count_o and the stored words unchanged.
- R8: An unload edge while empty sets err_o and leaves count_o and data_o unchanged.
- R9: err_o stays 1 until clear_err_i is sampled high at a clock edge. If a new error occurs in that same cycle, err_o stays 1.
- R10: Load and unload edges in the same cycle are applied as unload first, then load. When full, both succeed, count_o stays at DEPTH and no error occurs. When empty, the unload fails and sets err_o, and the load succeeds so count_o becomes 1.
- R11: data_o holds the last unloaded word until the next successful unload. All outputs change one clock after the triggering edge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_req_i | input | 1 | Load request, acts on its rising edge |
| unload_req_i | input | 1 | Unload request, acts on its rising edge |
| clear_err_i | input | 1 | Synchronous clear of the error flag |
| data_i | input | DATA_W (16) | Word to be loaded |
| data_o | output | DATA_W (16) | Last unloaded word |
| count_o | output | $clog2(DEPTH+1) | Number of words held |
| full_o | output | 1 | Count equals DEPTH |
| empty_o | output | 1 | Count is zero |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
A wrong slot shift, a wrong write index or a wrong read index stays hidden in the array. It shows at data_o only when the affected word is unloaded, which can be up to DEPTH unloads later. For that reason the random traffic drains the buffer often. A count that drifts shows at count_o, full_o and empty_o on the very next clock, and it later shows as a false or missing error. A broken edge detector shows as count_o moving on every cycle while a request is held high. This surfaces within one clock of the held level.

// File: rtl/word_stack_pkg.sv
package word_stack_pkg;
  typedef enum logic {
    ORDER_FIFO = 1'b0,
    ORDER_LIFO = 1'b1
  } order_e;

  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned DEPTH_DEF  = 5;
endpackage

// File: rtl/word_stack_edge.sv
module word_stack_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/word_stack_ctrl.sv
module word_stack_ctrl #(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_evt_i,
  input  logic             ul_evt_i,
  input  logic             clear_err_i,
  output logic             ld_ok_o,
  output logic             ul_ok_o,
  output logic [CNT_W-1:0] wr_idx_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;
  logic             err_q, ul_err, ld_err;

  // unload resolves first; load sees the post-unload count
  always_comb begin
    ul_ok_o  = ul_evt_i & (cnt_q != '0);
    ul_err   = ul_evt_i & (cnt_q == '0);
    cnt_mid  = cnt_q - CNT_W'(ul_ok_o);
    ld_ok_o  = ld_evt_i & (cnt_mid != CNT_MAX);
    ld_err   = ld_evt_i & (cnt_mid == CNT_MAX);
    cnt_d    = cnt_mid + CNT_W'(ld_ok_o);
    wr_idx_o = cnt_mid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ul_err | ld_err)  err_q <= 1'b1;
      else if (clear_err_i) err_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/word_stack_store.sv
module word_stack_store #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WORD_W-1:0] above;
    if (i < DEPTH - 1) begin : g_mid
      assign above = slot_q[i+1];
    end else begin : g_top
      assign above = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q[i] <= '0;
      else if (wr_en_i && (wr_idx_i == CNT_W'(i)))   slot_q[i] <= wr_data_i;
      else if (shift_i)                              slot_q[i] <= above;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == CNT_W'(i)) rd_data_o = slot_q[i];
    end
  end
endmodule

// File: rtl/word_stack.sv
module word_stack #(
  parameter int unsigned WORD_W = word_stack_pkg::WORD_W_DEF,
  parameter int unsigned DEPTH  = word_stack_pkg::DEPTH_DEF,
  parameter word_stack_pkg::order_e ORDER = word_stack_pkg::ORDER_FIFO,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_req_i,
  input  logic              unload_req_i,
  input  logic              clear_err_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  logic             ld_evt, ul_evt, ld_ok, ul_ok;
  logic [CNT_W-1:0] wr_idx, cnt, rd_idx;
  logic [WORD_W-1:0] rd_data, data_q;

  word_stack_edge u_ld_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(load_req_i), .rise_o(ld_evt)
  );
  word_stack_edge u_ul_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(unload_req_i), .rise_o(ul_evt)
  );

  word_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_evt_i   (ld_evt),
    .ul_evt_i   (ul_evt),
    .clear_err_i(clear_err_i),
    .ld_ok_o    (ld_ok),
    .ul_ok_o    (ul_ok),
    .wr_idx_o   (wr_idx),
    .cnt_o      (cnt),
    .err_o      (err_o)
  );

  logic shift;
  if (ORDER == word_stack_pkg::ORDER_FIFO) begin : g_fifo
    assign rd_idx = '0;
    assign shift  = ul_ok;
  end else begin : g_lifo
    assign rd_idx = cnt - CNT_W'(1);
    assign shift  = 1'b0;
  end

  word_stack_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift),
    .wr_en_i  (ld_ok),
    .wr_idx_i (wr_idx),
    .wr_data_i(data_i),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (ul_ok) data_q <= rd_data;
  end

  assign data_o  = data_q;
  assign count_o = cnt;
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
endmodule

// File: rtl/word_stack_chk.sv
module word_stack_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_req_i,
  input logic              unload_req_i,
  input logic              clear_err_i,
  input logic [WORD_W-1:0] data_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_o
);
  logic ld_p, ul_p, ld_e, ul_e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_p <= 1'b0;
      ul_p <= 1'b0;
    end else begin
      ld_p <= load_req_i;
      ul_p <= unload_req_i;
    end
  end

  assign ld_e = load_req_i & ~ld_p;
  assign ul_e = unload_req_i & ~ul_p;

  // R6
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  // R6
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R2
  load_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_e && !ul_e && !full_o |=> count_o == $past(count_o) + CNT_W'(1));

  // R2
  load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_e && !ul_e |=> count_o == $past(count_o));

  // R7
  overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_e && !ul_e && full_o |=> err_o && count_o == $past(count_o));

  // R8
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ul_e && !ld_e && empty_o |=> err_o && count_o == '0 && data_o == $past(data_o));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clear_err_i |=> err_o);

  // R10
  swap_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_e && ul_e && full_o && !err_o |=> full_o && !err_o);
endmodule

bind word_stack word_stack_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_req_i  (load_req_i),
  .unload_req_i(unload_req_i),
  .clear_err_i (clear_err_i),
  .data_o      (data_o),
  .count_o     (count_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .err_o       (err_o)
);

// File: tb/word_stack_tb.sv
module word_stack_tb;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned DEPTH  = 5;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_req_i = 1'b0, unload_req_i = 1'b0, clear_err_i = 1'b0;
  logic [WORD_W-1:0] data_i = '0;
  logic [WORD_W-1:0] data_f, data_l;
  logic [CNT_W-1:0]  cnt_f, cnt_l;
  logic full_f, full_l, empty_f, empty_l, err_f, err_l;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  word_stack #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ORDER(word_stack_pkg::ORDER_FIFO)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_req_i(load_req_i), .unload_req_i(unload_req_i),
    .clear_err_i(clear_err_i), .data_i(data_i), .data_o(data_f), .count_o(cnt_f),
    .full_o(full_f), .empty_o(empty_f), .err_o(err_f)
  );

  word_stack #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ORDER(word_stack_pkg::ORDER_LIFO)) u_dut_lifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_req_i(load_req_i), .unload_req_i(unload_req_i),
    .clear_err_i(clear_err_i), .data_i(data_i), .data_o(data_l), .count_o(cnt_l),
    .full_o(full_l), .empty_o(empty_l), .err_o(err_l)
  );

  // reference models: index 0 queue order, index 1 stack order
  logic [WORD_W-1:0] mq [2][DEPTH];
  int                mc [2];
  logic [WORD_W-1:0] md [2];
  bit                me [2];
  bit                ld_prev = 1'b0, ul_prev = 1'b0;

  task automatic model_step(int m, bit le, bit ue, bit clr, logic [WORD_W-1:0] d);
    bit fault = 1'b0;
    if (ue) begin
      if (mc[m] == 0) fault = 1'b1;
      else begin
        if (m == 0) begin
          md[m] = mq[m][0];
          for (int i = 0; i < DEPTH - 1; i++) mq[m][i] = mq[m][i+1];
        end else begin
          md[m] = mq[m][mc[m]-1];
        end
        mc[m]--;
      end
    end
    if (le) begin
      if (mc[m] == DEPTH) fault = 1'b1;
      else begin
        mq[m][mc[m]] = d;
        mc[m]++;
      end
    end
    if (fault) me[m] = 1'b1;
    else if (clr) me[m] = 1'b0;
  endtask

  function automatic bit exp_full(int m);
    return mc[m] == DEPTH;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "fifo count", int'(cnt_f), mc[0]);
    chk(tag, "fifo data", int'(data_f), int'(md[0]));
    chk(tag, "fifo err", int'(err_f), int'(me[0]));
    chk(tag, "fifo full", int'(full_f), int'(exp_full(0)));
    chk(tag, "fifo empty", int'(empty_f), int'(mc[0] == 0));
    chk(tag, "lifo count", int'(cnt_l), mc[1]);
    chk(tag, "lifo data", int'(data_l), int'(md[1]));
    chk(tag, "lifo err", int'(err_l), int'(me[1]));
    chk(tag, "lifo full", int'(full_l), int'(exp_full(1)));
    chk(tag, "lifo empty", int'(empty_l), int'(mc[1] == 0));
  endtask

  task automatic step(bit ld, bit ul, bit clr, logic [WORD_W-1:0] d, string tag);
    bit le, ue;
    @(negedge clk_i);
    load_req_i = ld; unload_req_i = ul; clear_err_i = clr; data_i = d;
    le = ld & ~ld_prev;
    ue = ul & ~ul_prev;
    ld_prev = ld; ul_prev = ul;
    @(posedge clk_i);
    #2;
    for (int m = 0; m < 2; m++) model_step(m, le, ue, clr, d);
    compare(tag);
  endtask

  task automatic do_load(logic [WORD_W-1:0] d, string tag);
    step(1'b1, 1'b0, 1'b0, d, tag);
    step(1'b0, 1'b0, 1'b0, d, tag);
  endtask

  task automatic do_unload(string tag);
    step(1'b0, 1'b1, 1'b0, '0, tag);
    step(1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      mc[m] = 0; md[m] = '0; me[m] = 1'b0;
      for (int i = 0; i < DEPTH; i++) mq[m][i] = '0;
    end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #2 compare("R1");
    @(negedge clk_i) rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b0, '0, "R1");

    // R2 R6: fill to full, with held-high periods
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 1'b0, WORD_W'(16'h1100 + i), "R2");
      step(1'b1, 1'b0, 1'b0, 16'hdead, "R2");
      step(1'b0, 1'b0, 1'b0, '0, "R6");
    end
    // R7 overflow
    do_load(16'hbeef, "R7");
    // R9 clear
    step(1'b0, 1'b0, 1'b1, '0, "R9");
    step(1'b0, 1'b0, 1'b0, '0, "R9");
    // R10 swap while full
    step(1'b1, 1'b1, 1'b0, 16'h5a5a, "R10");
    step(1'b0, 1'b0, 1'b0, '0, "R10");
    // R3 R4 R5: drain, with held unload
    step(1'b0, 1'b1, 1'b0, '0, "R3");
    step(1'b0, 1'b1, 1'b0, '0, "R3");
    step(1'b0, 1'b0, 1'b0, '0, "R11");
    for (int i = 1; i < DEPTH; i++) do_unload(i[0] ? "R4" : "R5");
    // R8 underflow
    do_unload("R8");
    // R9 error set and clear together
    step(1'b0, 1'b1, 1'b1, '0, "R9");
    step(1'b0, 1'b0, 1'b1, '0, "R9");
    // R10 both while empty
    step(1'b1, 1'b1, 1'b0, 16'h7777, "R10");
    step(1'b0, 1'b0, 1'b1, '0, "R10");
    do_unload("R11");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit ld, ul, clr;
      ld  = ($urandom % 3) == 0;
      ul  = ($urandom % 3) == 0;
      clr = ($urandom % 16) == 0;
      step(ld, ul, clr, WORD_W'($urandom), "R11");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule